// File: doc/BRIEF.md
# BCD Calendar Counter with Snapshot and Write Buffer

This block keeps the time of day and the calendar in BCD registers. A single-cycle tick, delivered once per second by logic outside the block, advances seconds, minutes, hours, date, month, year, century and day-of-week. Hours can run in 24-hour form or in 12-hour form with a PM flag, chosen by the top bit of the hour byte.

A serial front end reaches the counters through two buffers. A read strobe copies the live time into a snapshot, and reads return snapshot bytes, so a multi-byte read sees one coherent instant while counting continues. A write transaction opens by copying the live time into a write buffer; incoming bytes replace buffer entries, and a commit strobe at a valid end of transaction loads the buffer into the counters, while an abort strobe throws it away. After reset, which stands for a total loss of power, the counters stay frozen and a fail flag stays high until the first committed write.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time is sec 00h, min 00h, hour 12h (12-hour form, AM), date 01h, month 01h, year 00h, day-of-week 00h, century 20h, and `fail_o` is 1. Byte indices are 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day-of-week, 7 century.
- R2: While `fail_o` is 1 ticks have no effect; the first commit that carries at least one written byte loads the time, drops `fail_o` to 0 and lets counting start.
- R3: Seconds and minutes count 00h to 59h in BCD; 59h wraps to 00h and carries into the next field.
- R4: With hour bit 7 set, the hour (bits 5:0) counts 00h to 23h; 23h wraps to 00h and starts a new day.
- R5: With hour bit 7 clear, bits 4:0 count 1 to 12 and bit 5 is PM (1 = PM); 11 steps to 12 and toggles PM, 12 steps to 1, and leaving 11 PM starts a new day.
- R6: The date wraps to 01h after 30h in months 04h, 06h, 09h and 11h, and after 31h in the other months except February, carrying into the month.
- R7: February ends on 29h when the BCD year is divisible by 4 (including 00h) and on 28h otherwise.
- R8: Month 12h wraps to 01h and advances the year; year 99h wraps to 00h and sets the century to 20h; a write of a century value other than 19h or 20h is ignored.
- R9: Day-of-week advances with each new day through 0 to 6 and wraps from 6 to 0.
- R10: A read strobe copies the live time into the snapshot; `rd_data` shows snapshot byte `rd_addr` and does not change while ticks advance the live time.
- R11: A write opens with a copy of the live time into the buffer; a commit loads the whole buffer, a tick in the commit cycle is ignored and counting resumes with the next tick; an abort discards the buffer and leaves the time running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (total power loss) |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| rd_latch | input | 1 | Copy live time into the snapshot |
| rd_addr | input | 3 | Snapshot byte index |
| rd_data | output | 8 | Snapshot byte at `rd_addr` |
| wr_open | input | 1 | Start a write: copy live time into the buffer |
| wr_en | input | 1 | Write `wr_data` into buffer entry `wr_addr` |
| wr_addr | input | 3 | Buffer byte index |
| wr_data | input | 8 | Byte to write |
| wr_commit | input | 1 | Valid end of write: load the buffer into the counters |
| wr_abort | input | 1 | Invalid end of write: discard the buffer |
| fail_o | output | 1 | Time not yet set since power loss |

## Verification
Every strobe takes effect at the next rising edge: a tick or a commit changes the live counters there, and a read strobe fills the snapshot there, after which `rd_data` follows `rd_addr` combinationally. The live time is only visible through the snapshot, so each directed check first pulses the read strobe for one cycle and then reads bytes a cycle later. Inputs move on the falling edge and outputs are sampled 1 ns after it, and the bench's behavioural model steps on the same rising edges, so its snapshot and fail flag are compared with the ports in every cycle.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rd_latch,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       wr_open,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       wr_commit,
  input  logic       wr_abort,
  output logic       fail_o
);
  localparam logic [7:0][7:0] RST_TIME =
    {RST_CENTURY, 8'h00, 8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00};

  logic [7:0][7:0] live, nxt, wbuf, snap;
  logic running, dirty;
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  logic leap, thirty, cen_ok, load;
  logic [7:0] dim, h24_inc, h12_inc;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign leap    = live[5][4] ? (live[5][3:0] == 4'd2 || live[5][3:0] == 4'd6)
                              : (live[5][3:0] == 4'd0 || live[5][3:0] == 4'd4 || live[5][3:0] == 4'd8);
  assign thirty  = live[4] == 8'h04 || live[4] == 8'h06 || live[4] == 8'h09 || live[4] == 8'h11;
  assign dim     = (live[4] == 8'h02) ? (leap ? 8'h29 : 8'h28) : (thirty ? 8'h30 : 8'h31);
  assign h24_inc = inc_bcd({2'b00, live[2][5:0]});
  assign h12_inc = inc_bcd({3'b000, live[2][4:0]});
  assign cen_ok  = wr_addr != 3'd7 || wr_data == 8'h19 || wr_data == 8'h20;
  assign load    = wr_commit && dirty;
  assign rd_data = snap[rd_addr];
  assign fail_o  = !running;

  always_comb begin
    nxt   = live;
    c_day = 1'b0;
    c_min = live[0] == 8'h59;
    c_hr  = c_min && live[1] == 8'h59;
    nxt[0] = c_min ? 8'h00 : inc_bcd(live[0]);
    if (c_min) nxt[1] = (live[1] == 8'h59) ? 8'h00 : inc_bcd(live[1]);
    if (c_hr) begin
      if (live[2][7]) begin
        if (live[2][5:0] == 6'h23) begin
          nxt[2] = 8'h80;
          c_day  = 1'b1;
        end else nxt[2] = {2'b10, h24_inc[5:0]};
      end else if (live[2][4:0] == 5'h11) begin
        nxt[2] = {2'b00, !live[2][5], 5'h12};
        c_day  = live[2][5];
      end else if (live[2][4:0] == 5'h12) nxt[2] = {2'b00, live[2][5], 5'h01};
      else nxt[2] = {2'b00, live[2][5], h12_inc[4:0]};
    end
    c_mon = c_day && live[3] == dim;
    c_yr  = c_mon && live[4] == 8'h12;
    c_cen = c_yr && live[5] == 8'h99;
    if (c_day) begin
      nxt[3] = c_mon ? 8'h01 : inc_bcd(live[3]);
      nxt[6] = (live[6][2:0] >= 3'd6) ? 8'h00 : {5'b0, live[6][2:0] + 3'd1};
    end
    if (c_mon) nxt[4] = c_yr ? 8'h01 : inc_bcd(live[4]);
    if (c_yr)  nxt[5] = c_cen ? 8'h00 : inc_bcd(live[5]);
    if (c_cen) nxt[7] = 8'h20;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= RST_TIME;
      wbuf    <= RST_TIME;
      snap    <= '0;
      running <= 1'b0;
      dirty   <= 1'b0;
    end else begin
      if (load) begin
        live    <= wbuf;
        running <= 1'b1;
      end else if (tick && running) live <= nxt;
      if (rd_latch) snap <= live;
      if (wr_commit || wr_abort) dirty <= 1'b0;
      else begin
        if (wr_open) begin
          wbuf  <= live;
          dirty <= 1'b0;
        end
        if (wr_en && cen_ok) begin
          wbuf[wr_addr] <= wr_data;
          dirty         <= 1'b1;
        end
      end
    end
  end

  AST_HALTED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(live)); // R2
  AST_FAIL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_o) |-> $past(load)); // R2
  AST_COMMIT_LOADS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (live == $past(wbuf))); // R11
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(live)); // R11
  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_latch |=> $stable(snap)); // R10
  AST_CENTURY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (live[7] == 8'h19 || live[7] == 8'h20)); // R8
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
`timescale 1ns/100ps
module bcd_rtc_core_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, rd_latch = 0, wr_open = 0, wr_en = 0;
  logic wr_commit = 0, wr_abort = 0;
  logic [2:0] rd_addr = 0, wr_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic fail_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = !clk;

  bcd_rtc_core dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .rd_latch(rd_latch),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_open(wr_open), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .fail_o(fail_o));

  // behavioural reference model
  int ms, mm, mh, mpm, mmil, md, mmo, my, mc, mw, mrun, mdirty;
  logic [7:0] mbuf [8];
  logic [7:0] msnap [8];

  function automatic logic [7:0] i2b(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(int i);
    case (i)
      0: return i2b(ms);
      1: return i2b(mm);
      2: return mmil != 0 ? (8'h80 | i2b(mh)) : ((mpm != 0 ? 8'h20 : 8'h00) | i2b(mh));
      3: return i2b(md);
      4: return i2b(mmo);
      5: return i2b(my);
      6: return i2b(mw);
      default: return i2b(mc);
    endcase
  endfunction

  task automatic model_reset();
    ms = 0; mm = 0; mh = 12; mpm = 0; mmil = 0; md = 1; mmo = 1; my = 0; mc = 20; mw = 0;
    mrun = 0; mdirty = 0;
    for (int i = 0; i < 8; i++) begin msnap[i] = 8'h00; mbuf[i] = enc(i); end
  endtask

  task automatic model_advance();
    int dim;
    bit newday;
    newday = 0;
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0;
        if (mmil != 0) begin mh++; if (mh == 24) begin mh = 0; newday = 1; end end
        else if (mh == 11) begin mh = 12; mpm = 1 - mpm; if (mpm == 0) newday = 1; end
        else if (mh == 12) mh = 1;
        else mh++;
      end
    end
    if (newday) begin
      mw = (mw >= 6) ? 0 : mw + 1;
      if (mmo == 2) dim = (my % 4 == 0) ? 29 : 28;
      else if (mmo == 4 || mmo == 6 || mmo == 9 || mmo == 11) dim = 30;
      else dim = 31;
      if (md == dim) begin
        md = 1;
        if (mmo == 12) begin
          mmo = 1;
          if (my == 99) begin my = 0; mc = 20; end else my++;
        end else mmo++;
      end else md++;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [7:0] ob [8];
      for (int i = 0; i < 8; i++) ob[i] = enc(i);
      if (wr_commit && mdirty != 0) begin
        ms = b2i(mbuf[0]); mm = b2i(mbuf[1]);
        mmil = mbuf[2][7];
        if (mmil != 0) mh = b2i({2'b00, mbuf[2][5:0]});
        else begin mpm = mbuf[2][5]; mh = b2i({3'b000, mbuf[2][4:0]}); end
        md = b2i(mbuf[3]); mmo = b2i(mbuf[4]); my = b2i(mbuf[5]);
        mw = b2i(mbuf[6]); mc = b2i(mbuf[7]); mrun = 1;
      end else if (tick && mrun != 0) model_advance();
      if (wr_commit || wr_abort) mdirty = 0;
      else begin
        if (wr_open) begin for (int i = 0; i < 8; i++) mbuf[i] = ob[i]; mdirty = 0; end
        if (wr_en && (wr_addr != 3'd7 || wr_data == 8'h19 || wr_data == 8'h20)) begin
          mbuf[wr_addr] = wr_data; mdirty = 1;
        end
      end
      if (rd_latch) for (int i = 0; i < 8; i++) msnap[i] = ob[i];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R2 flag, R10 snapshot)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(fail_o == (mrun == 0), "R2 model fail flag", int'(fail_o), int'(mrun == 0));
      chk(rd_data == msnap[rd_addr], "R10 model snapshot", int'(rd_data), int'(msnap[rd_addr]));
    end
  end

  function automatic logic [63:0] pk(logic [7:0] s, m, h, d, mo, y, w, c);
    return {c, w, y, mo, d, h, m, s};
  endfunction

  task automatic tk(int n);
    repeat (n) begin @(negedge clk) tick = 1; @(negedge clk) tick = 0; end
  endtask

  task automatic latch();
    @(negedge clk) rd_latch = 1;
    @(negedge clk) rd_latch = 0;
  endtask

  task automatic peek(int a, output logic [7:0] v);
    @(negedge clk) rd_addr = 3'(a);
    #1 v = rd_data;
  endtask

  task automatic chk_byte(int a, logic [7:0] exp, string req);
    logic [7:0] v;
    latch();
    peek(a, v);
    chk(v == exp, req, int'(v), int'(exp));
  endtask

  task automatic chk_time(logic [63:0] exp, string req);
    logic [7:0] v;
    latch();
    for (int i = 0; i < 8; i++) begin
      peek(i, v);
      chk(v == exp[i*8 +: 8], req, int'(v), int'(exp[i*8 +: 8]));
    end
  endtask

  task automatic set_time(logic [63:0] t);
    @(negedge clk) wr_open = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) wr_open = 0; wr_en = 1; wr_addr = 3'(i); wr_data = t[i*8 +: 8];
    end
    @(negedge clk) wr_en = 0; wr_commit = 1;
    @(negedge clk) wr_commit = 0;
  endtask

  task automatic wr_one(int a, logic [7:0] d);
    @(negedge clk) wr_open = 1;
    @(negedge clk) wr_open = 0; wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk) wr_en = 0; wr_commit = 1;
    @(negedge clk) wr_commit = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(fail_o == 1'b1, "R1 fail flag", int'(fail_o), 1);
    chk_time(pk(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20), "R1 reset time");
    // R2 frozen until first write
    tk(3);
    chk_byte(0, 8'h00, "R2 frozen seconds");
    wr_one(0, 8'h05);
    chk(fail_o == 1'b0, "R2 fail cleared", int'(fail_o), 0);
    chk_byte(0, 8'h05, "R2 written seconds");
    tk(1);
    chk_byte(0, 8'h06, "R2 counting started");
    // R11 tick in commit cycle ignored
    @(negedge clk) wr_open = 1;
    @(negedge clk) wr_open = 0; wr_en = 1; wr_addr = 0; wr_data = 8'h40;
    @(negedge clk) wr_en = 0; wr_commit = 1; tick = 1;
    @(negedge clk) wr_commit = 0; tick = 0;
    chk_byte(0, 8'h40, "R11 commit beats tick");
    tk(1);
    chk_byte(0, 8'h41, "R11 resumes next tick");
    // R3 R4 R8 R9 full rollover
    set_time(pk(8'h58, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06, 8'h19));
    tk(1);
    chk_byte(0, 8'h59, "R3 seconds step");
    tk(1);
    chk_time(pk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20), "R3 R4 R8 R9 rollover");
    // R5 12-hour
    set_time(pk(8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h24, 8'h02, 8'h20));
    tk(1);
    chk_byte(2, 8'h32, "R5 11AM to 12PM");
    set_time(pk(8'h59, 8'h59, 8'h32, 8'h05, 8'h03, 8'h24, 8'h02, 8'h20));
    tk(1);
    chk_byte(2, 8'h21, "R5 12PM to 1PM");
    set_time(pk(8'h59, 8'h59, 8'h31, 8'h05, 8'h03, 8'h24, 8'h02, 8'h20));
    tk(1);
    chk_time(pk(8'h00, 8'h00, 8'h12, 8'h06, 8'h03, 8'h24, 8'h03, 8'h20), "R5 R9 11PM to 12AM");
    // R6 month lengths
    set_time(pk(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h24, 8'h00, 8'h20));
    tk(1);
    chk_time(pk(8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h24, 8'h01, 8'h20), "R6 30-day month");
    set_time(pk(8'h59, 8'h59, 8'hA3, 8'h30, 8'h05, 8'h24, 8'h00, 8'h20));
    tk(1);
    chk_byte(3, 8'h31, "R6 31-day month");
    // R7 February
    set_time(pk(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h00, 8'h20));
    tk(1);
    chk_byte(3, 8'h29, "R7 leap 24 day 29");
    set_time(pk(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h00, 8'h20));
    tk(1);
    chk_byte(4, 8'h03, "R7 leap 24 to March");
    set_time(pk(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h00, 8'h20));
    tk(1);
    chk_byte(3, 8'h01, "R7 non-leap 23");
    set_time(pk(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 8'h00, 8'h20));
    tk(1);
    chk_byte(3, 8'h29, "R7 year 00 leap");
    // R8 century writes
    wr_one(7, 8'h21);
    chk_byte(7, 8'h20, "R8 illegal century ignored");
    wr_one(7, 8'h19);
    chk_byte(7, 8'h19, "R8 century 19 accepted");
    // R10 snapshot coherence
    set_time(pk(8'h10, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20));
    begin
      logic [7:0] v;
      latch();
      tk(5);
      peek(0, v);
      chk(v == 8'h10, "R10 snapshot held", int'(v), 16);
    end
    chk_byte(0, 8'h15, "R10 relatch sees live");
    // R11 abort and stale buffer
    @(negedge clk) wr_open = 1;
    @(negedge clk) wr_open = 0; wr_en = 1; wr_addr = 0; wr_data = 8'h45;
    @(negedge clk) wr_en = 0; wr_abort = 1;
    @(negedge clk) wr_abort = 0;
    chk_byte(0, 8'h15, "R11 abort discards");
    @(negedge clk) wr_open = 1;
    @(negedge clk) wr_open = 0;
    tk(2);
    @(negedge clk) wr_en = 1; wr_addr = 1; wr_data = 8'h07;
    @(negedge clk) wr_en = 0; wr_commit = 1;
    @(negedge clk) wr_commit = 0;
    chk_byte(0, 8'h15, "R11 buffer from open");
    chk_byte(1, 8'h07, "R11 written minute");
    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule